// File: doc/BRIEF.md
# Free-running-clock SPI master

This block is an 8-bit SPI master that shifts a byte out on MOSI while it shifts a byte in from MISO, most significant bit first. Its bit-rate divider counts continuously from the system clock whenever the block is enabled in master mode. Accepting a byte does not restart the divider. The byte waits until the divider next crosses a bit-period boundary, and the transfer opens there. The delay from acceptance to the first activity on the serial lines therefore depends on where the divider happened to be. That delay is bounded by one bit period.

Bytes to send enter through a valid/ready port. `tx_ready` is high only while the block is enabled, in master mode and idle. A source may raise `tx_valid` at any time and must hold `tx_data` stable until the cycle in which both signals are high. Nothing is lost while the block is busy, because the source simply waits. The received byte and the completion flag are plain status outputs. Both clock polarities and both clock phases are selected by static pins, and a 2-bit rate code chooses the bit period.

Top module: `spi_freerun_master`

## Requirements
- R1: A transfer starts only after a handshake (`tx_valid` and `tx_ready` both high at a rising clock edge). `tx_ready` is high only when `en` and `mstr` are both 1 and no transfer is pending or running.
- R2: The divider counts only while `en` and `mstr` are both 1. Clearing either one stops any pending or running transfer. On the next edge `ss_n` returns high and `sck` returns to its idle level, and `done` is not set.
- R3: The rate code sets the bit period: code 0 gives 2 clocks, 1 gives 8, 2 gives 32 and 3 gives 128. Inside a transfer, consecutive SCK edges are exactly half a bit period apart.
- R4: `ss_n` falls between 1 and one bit period of clock edges after the accepting edge, and only on a divider bit boundary. The exact delay depends on the divider phase at acceptance.
- R5: Outside a transfer, `sck` equals `cpol` (0 gives idle low, 1 gives idle high).
- R6: With `cpha` 0, `sck` stays idle for the first half bit after `ss_n` falls. With `cpha` 1, `sck` moves to its active level in the same cycle in which `ss_n` falls.
- R7: Each transfer makes exactly 16 SCK edges. MOSI carries the byte MSB first and holds each bit on the sampling edge: the leading edge for `cpha` 0 and the trailing edge for `cpha` 1.
- R8: MISO is sampled MSB first on the same sampling edges. When `done` rises, `rx_data` holds the received byte.
- R9: `ss_n` stays low for the whole transfer and rises together with `done`. `done` clears at the next accepted handshake.
- R10: A `tx_valid` held while `tx_ready` is low is accepted once the running transfer ends, and its data is the byte sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Block enable |
| mstr | input | 1 | Master-mode select; the divider runs only with en |
| cpol | input | 1 | SCK idle level |
| cpha | input | 1 | Clock phase select |
| rate | input | 2 | Bit period code (2, 8, 32, 128 clocks) |
| tx_valid | input | 1 | Byte to send is offered |
| tx_ready | output | 1 | Block can accept a byte |
| tx_data | input | 8 | Byte to send |
| miso | input | 1 | Serial data from slave |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to slave |
| ss_n | output | 1 | Slave select, active low |
| done | output | 1 | Last transfer completed |
| rx_data | output | 8 | Last received byte |

## Verification
The hardest condition to reach from the ports is a spread of start latencies. The divider phase cannot be seen or set directly, so the bench can reach different phases only through its own timing. After a completed transfer the divider sits on a bit boundary. The bench then waits a different number of idle cycles before each new write at the 8-clock rate. This sweeps the acceptance point across every divider phase, and the bench checks that the measured latencies are bounded and not all equal. The sixteen rate and mode combinations come from a vector table, and a behavioural slave in the bench answers on MISO.

// File: rtl/spim_pkg.sv
package spim_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_XFER  = 2'd2
  } seq_state_t;

  // bit period in system clocks for a rate code: 2, 8, 32, 128
  function automatic int unsigned period_of(input logic [1:0] code);
    return 32'd2 << (2 * code);
  endfunction

endpackage

// File: rtl/spim_rate_gen.sv
module spim_rate_gen
  import spim_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] rate,
  output logic       half_tick,
  output logic       bit_tick
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] bit_mask;
  logic [CNT_W-1:0] half_mask;

  always_comb begin
    bit_mask  = CNT_W'(period_of(rate) - 1);
    half_mask = bit_mask >> 1;
  end

  // free-running; only held at zero while the block is stopped
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (!run) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  assign half_tick = run && ((cnt & half_mask) == half_mask);
  assign bit_tick  = run && ((cnt & bit_mask) == bit_mask);

  // R3: every bit boundary is also a half-bit boundary
  a_r3_bit_on_half: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> half_tick);

  // R2: a stopped divider restarts from zero, so no tick in the first run cycle unless rate 0
  a_r2_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !$past(run) && rate != 2'd0) |-> !bit_tick);

endmodule

// File: rtl/spim_seq.sv
module spim_seq
  import spim_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              half_tick,
  input  logic              bit_tick,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_ready,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic              ss_act,
  output logic              done,
  output logic [DATA_W-1:0] rx_data
);

  localparam int HALF_N = 2 * DATA_W;
  localparam int HC_W   = $clog2(HALF_N);
  localparam logic [HC_W-1:0] LAST_HALF = HC_W'(HALF_N - 1);

  seq_state_t        state;
  logic [HC_W-1:0]   hcnt;
  logic [DATA_W-1:0] tx_sh;
  logic [DATA_W-1:0] rx_sh;
  logic              in_xfer;

  assign in_xfer  = (state == ST_XFER);
  assign tx_ready = run && (state == ST_IDLE);
  assign ss_act   = in_xfer;
  assign mosi     = tx_sh[DATA_W-1];
  // even halves: sampling edge at their end; odd halves: shifting edge
  assign sck      = cpol ^ (in_xfer && (hcnt[0] != cpha));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      hcnt    <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      done    <= 1'b0;
      rx_data <= '0;
    end else if (!run) begin
      state <= ST_IDLE;
      hcnt  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (tx_valid) begin
            tx_sh <= tx_data;
            done  <= 1'b0;
            state <= ST_ARMED;
          end
        end
        ST_ARMED: begin
          if (bit_tick) begin
            hcnt  <= '0;
            state <= ST_XFER;
          end
        end
        ST_XFER: begin
          if (half_tick) begin
            if (!hcnt[0]) begin
              rx_sh <= {rx_sh[DATA_W-2:0], miso};
            end else if (hcnt != LAST_HALF) begin
              tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
            end
            if (hcnt == LAST_HALF) begin
              rx_data <= rx_sh;
              done    <= 1'b1;
              hcnt    <= '0;
              state   <= ST_IDLE;
            end else begin
              hcnt <= hcnt + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9: completion is reported only at the end of a running transfer
  a_r9_done_from_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(state) == ST_XFER) && (state == ST_IDLE));

  // R1: a pending transfer exists only after a handshake
  a_r1_arm_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ARMED && $past(state) == ST_IDLE) |-> $past(tx_valid && tx_ready));

  // R7: MOSI is unchanged across a sampling half boundary
  a_r7_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (in_xfer && half_tick && !hcnt[0]) |=> $stable(mosi));

endmodule

// File: rtl/spi_freerun_master.sv
module spi_freerun_master
  import spim_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 7,
  parameter bit SS_EN  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              mstr,
  input  logic              cpol,
  input  logic              cpha,
  input  logic [1:0]        rate,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic              ss_n,
  output logic              done,
  output logic [DATA_W-1:0] rx_data
);

  localparam int PER_W = CNT_W + 1;

  logic run;
  logic half_tick;
  logic bit_tick;
  logic ss_act;

  assign run = en && mstr;

  spim_rate_gen #(.CNT_W(CNT_W)) u_rate (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .rate      (rate),
    .half_tick (half_tick),
    .bit_tick  (bit_tick)
  );

  spim_seq #(.DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .cpol      (cpol),
    .cpha      (cpha),
    .half_tick (half_tick),
    .bit_tick  (bit_tick),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .tx_ready  (tx_ready),
    .miso      (miso),
    .sck       (sck),
    .mosi      (mosi),
    .ss_act    (ss_act),
    .done      (done),
    .rx_data   (rx_data)
  );

  generate
    if (SS_EN) begin : g_ss
      assign ss_n = ~ss_act;
    end else begin : g_no_ss
      assign ss_n = 1'b1;
    end
  endgenerate

  // checker: cycles spent waiting for a bit boundary
  logic             armed;
  logic [PER_W-1:0] wait_cnt;
  logic [PER_W-1:0] period;

  assign armed  = run && !tx_ready && !ss_act;
  assign period = PER_W'(period_of(rate));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     wait_cnt <= '0;
    else if (armed) wait_cnt <= wait_cnt + 1'b1;
    else            wait_cnt <= '0;
  end

  // R4: start latency never exceeds one bit period
  a_r4_latency_bound: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (wait_cnt < period));

  // R4: transfers open only on a divider bit boundary
  a_r4_start_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ss_act) |-> $past(bit_tick));

  // R5: idle clock level follows polarity
  a_r5_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !ss_act |-> (sck == cpol));

  // R6: phase 1 opens with the active level, phase 0 with the idle level
  a_r6_first_half: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ss_act) |-> (sck == (cpol ^ cpha)));

  // R1: no handshake is offered while a transfer runs
  a_r1_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> !ss_act);

  // R2: stopping the block releases the bus at once
  a_r2_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !ss_act);

endmodule

// File: tb/spi_freerun_master_tb.sv
module spi_freerun_master_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0, mstr = 1'b0, cpol = 1'b0, cpha = 1'b0;
  logic [1:0] rate = 2'd0;
  logic       tx_valid = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_ready, sck, mosi, ss_n, done;
  logic [7:0] rx_data;
  logic       miso_r = 1'b0;

  always #4 clk = ~clk;

  spi_freerun_master u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .mstr(mstr), .cpol(cpol), .cpha(cpha),
    .rate(rate), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .miso(miso_r), .sck(sck), .mosi(mosi), .ss_n(ss_n), .done(done),
    .rx_data(rx_data)
  );

  // rate, cpol, cpha, byte sent, byte answered by slave
  localparam logic [19:0] VEC [0:15] = '{
    {2'd0, 1'b0, 1'b0, 8'hA5, 8'h3C}, {2'd0, 1'b0, 1'b1, 8'h81, 8'h7E},
    {2'd0, 1'b1, 1'b0, 8'h5A, 8'hC3}, {2'd0, 1'b1, 1'b1, 8'h01, 8'h80},
    {2'd1, 1'b0, 1'b0, 8'hF0, 8'h0F}, {2'd1, 1'b0, 1'b1, 8'h96, 8'h69},
    {2'd1, 1'b1, 1'b0, 8'h80, 8'h01}, {2'd1, 1'b1, 1'b1, 8'hFF, 8'h00},
    {2'd2, 1'b0, 1'b0, 8'h00, 8'hFF}, {2'd2, 1'b0, 1'b1, 8'h33, 8'hCC},
    {2'd2, 1'b1, 1'b0, 8'hC6, 8'h39}, {2'd2, 1'b1, 1'b1, 8'h4B, 8'hB4},
    {2'd3, 1'b0, 1'b0, 8'hE1, 8'h1E}, {2'd3, 1'b0, 1'b1, 8'h2D, 8'hD2},
    {2'd3, 1'b1, 1'b0, 8'h77, 8'h88}, {2'd3, 1'b1, 1'b1, 8'h9C, 8'h63}
  };

  int checks = 0, errors = 0;
  bit reported = 1'b0;

  // observation state, written only by the monitor
  int cyc = 0, fall_cyc = 0, last_edge = 0, first_gap = -1;
  int mon_edges = 0, space_bad = 0, idle_bad = 0, fin_cnt = 0, sbit = 0;
  logic [7:0] mon_mosi = 8'h00;
  logic prev_ss = 1'b1, prev_sck = 1'b0, done_at_rise = 1'b0;
  // transfer context, written by the driver
  logic [7:0] cur_miso = 8'h00;
  int cur_half = 1, acc_cyc = 0;

  task automatic check(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // behavioural slave and timing monitor
  always @(negedge clk) begin
    logic lead;
    cyc++;
    if (prev_ss && !ss_n) begin
      fall_cyc = cyc; mon_edges = 0; mon_mosi = 8'h00; space_bad = 0;
      first_gap = -1; sbit = 7;
      if (!cpha) begin miso_r = cur_miso[7]; sbit = 6; end
    end
    if ((!ss_n || !prev_ss) && (sck !== prev_sck)) begin
      lead = (sck != cpol);
      if (mon_edges == 0) first_gap = cyc - fall_cyc;
      else if (cyc - last_edge != cur_half) space_bad++;
      last_edge = cyc;
      mon_edges++;
      if (lead == !cpha) mon_mosi = {mon_mosi[6:0], mosi};
      else if (sbit >= 0) begin miso_r = cur_miso[sbit]; sbit--; end
    end
    if (ss_n && prev_ss && (sck !== cpol)) idle_bad++;
    if (!prev_ss && ss_n) begin done_at_rise = done; fin_cnt++; end
    prev_ss = ss_n;
    prev_sck = sck;
  end

  task automatic send(input logic [7:0] d);
    @(negedge clk); #2;
    tx_valid = 1'b1; tx_data = d;
    while (!tx_ready) begin @(negedge clk); #2; end
    acc_cyc = cyc;
    @(negedge clk); #2;
    tx_valid = 1'b0;
  endtask

  task automatic wait_fin(input int f0);
    while (fin_cnt == f0) @(negedge clk);
    #2;
  endtask

  task automatic run_one(input logic [7:0] txb, input logic [7:0] rxb, output int lat);
    int f0;
    f0 = fin_cnt;
    cur_miso = rxb;
    send(txb);
    wait_fin(f0);
    lat = fall_cyc - acc_cyc - 1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check("watchdog", 1'b0, 0, 1);
    report();
  end

  initial begin
    int lat, per, mn, mx, f0, rdy_seen;
    // reset state and stopped block (R1, R2, R5, R9)
    repeat (3) @(negedge clk);
    #2;
    check("R9 reset ss_n", ss_n === 1'b1, ss_n, 1);
    check("R5 reset sck", sck === 1'b0, sck, 0);
    check("R9 reset done", done === 1'b0, done, 0);
    rst_n = 1'b1;
    en = 1'b1; tx_valid = 1'b1; tx_data = 8'h55;
    rdy_seen = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); #2;
      if (tx_ready || !ss_n) rdy_seen++;
    end
    tx_valid = 1'b0;
    check("R1 no ready without mstr", rdy_seen == 0, rdy_seen, 0);
    check("R2 no transfer without mstr", fin_cnt == 0, fin_cnt, 0);
    mstr = 1'b1;

    // vector table: all rates and modes
    for (int v = 0; v < 16; v++) begin
      @(negedge clk); #2;
      rate = VEC[v][19:18]; cpol = VEC[v][17]; cpha = VEC[v][16];
      per = 2 << (2 * int'(rate));
      cur_half = per / 2;
      run_one(VEC[v][15:8], VEC[v][7:0], lat);
      check("R7 edge count", mon_edges == 16, mon_edges, 16);
      check("R7 mosi msb first", mon_mosi == VEC[v][15:8], mon_mosi, VEC[v][15:8]);
      check("R8 rx byte", rx_data == VEC[v][7:0], rx_data, VEC[v][7:0]);
      check("R4 latency bound", lat >= 1 && lat <= per, lat, per);
      check("R3 half spacing", space_bad == 0, space_bad, 0);
      check("R6 first edge", first_gap == (cpha ? 0 : cur_half), first_gap,
            cpha ? 0 : cur_half);
      check("R9 done with ss rise", done_at_rise === 1'b1, done_at_rise, 1);
    end
    check("R5 idle level", idle_bad == 0, idle_bad, 0);

    // latency spread across divider phases (R4)
    @(negedge clk); #2;
    rate = 2'd1; cpol = 1'b0; cpha = 1'b0; cur_half = 4;
    mn = 1000; mx = 0;
    for (int off = 0; off < 8; off++) begin
      repeat (off) @(negedge clk);
      run_one(8'h3A + 8'(off), 8'h5C, lat);
      if (lat < mn) mn = lat;
      if (lat > mx) mx = lat;
    end
    check("R4 max latency", mx <= 8 && mn >= 1, mx, 8);
    check("R4 latency varies", mx > mn, mx - mn, 1);

    // back-pressure and done clear (R10, R9)
    f0 = fin_cnt;
    cur_miso = 8'hA0;
    send(8'hC8);
    check("R9 done cleared by accept", done === 1'b0, done, 0);
    @(negedge clk); #2;
    tx_valid = 1'b1; tx_data = 8'h6D;
    rdy_seen = 0;
    while (fin_cnt == f0) begin
      if (tx_ready) rdy_seen++;
      @(negedge clk); #2;
    end
    check("R10 no ready while busy", rdy_seen == 0, rdy_seen, 0);
    check("R7 first byte", mon_mosi == 8'hC8, mon_mosi, 8'hC8);
    while (!tx_ready) begin @(negedge clk); #2; end
    acc_cyc = cyc;
    @(negedge clk); #2;
    tx_valid = 1'b0;
    wait_fin(f0 + 1);
    check("R10 held byte sent", mon_mosi == 8'h6D, mon_mosi, 8'h6D);

    // abort by clearing enable (R2)
    rate = 2'd3; cpol = 1'b1; cpha = 1'b1; cur_half = 64;
    f0 = fin_cnt;
    send(8'hB2);
    while (ss_n) @(negedge clk);
    repeat (20) @(negedge clk);
    #2; en = 1'b0;
    @(negedge clk); #2;
    check("R2 abort ss_n", ss_n === 1'b1, ss_n, 1);
    check("R2 abort sck idle", sck === cpol, sck, cpol);
    check("R2 abort no done", done === 1'b0, done, 0);
    check("R1 no ready when off", tx_ready === 1'b0, tx_ready, 0);
    en = 1'b1;
    report();
  end

endmodule